// File: doc/BRIEF.md
# Asynchronous Memory Chip-Select Sequencer

This block takes one read or write at a time from an internal host port and plays it out as a single cycle on an external asynchronous memory bus. Each access moves one word of the configured data width. The block drives the address, an active-low chip select, separate active-low read and write strobes, and an active-low start strobe that marks the opening of the chip-select window. The data bus is split into an output, an output enable and an input.

Every interval of the cycle comes from one configuration word. The word sets:

- how long the address leads and trails chip select;
- how long each strobe waits after chip select asserts;
- how long chip select stays low after the strobe lifts;
- a wait code that stretches the strobe;
- the start-strobe length;
- the idle gap inserted before an access.

The gap depends on what the previous access was, what the next one is, and whether both fall in the same address area. A field set to zero removes its phase without spending a cycle.

The host offers a request while `req_ready` is high. The configuration word is sampled in that same cycle. When the cycle finishes, `rsp_done` pulses and, for reads, `rsp_rdata` holds the captured word.

Top module: `sram_cs_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_done` is 0, `mem_cs_n`, `mem_rd_n`, `mem_we_n` and `mem_bs_n` are 1, `mem_dq_oe` is 0 and `mem_addr` is 0.
- R2: A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the next cycle until the cycle in which `rsp_done` is 1. `rsp_done` is 1 for exactly one cycle, and `req_ready` is 1 in that same cycle.
- R3: Outside an access `mem_addr` is parked at 0. The request address appears for exactly `addr_setup` cycles (bits [2:0]) with chip select high before chip select goes low. It stays for exactly `addr_hold` cycles (bits [5:3]) after chip select rises. It does not change while chip select is low.
- R4: On a read, `mem_rd_n` goes low exactly `rd_setup` cycles (bits [8:6]) after chip select goes low. Chip select stays low exactly `rd_hold` cycles (bits [11:9]) after `mem_rd_n` rises.
- R5: On a write, the same rule applies to `mem_we_n` with `wr_setup` (bits [14:12]) and `wr_hold` (bits [17:15]). `mem_dq_oe` is 1 with `mem_dq_o` equal to the write word during every chip-select-low cycle of a write. `mem_dq_oe` is 0 during reads.
- R6: The strobe stays low for 1 + W cycles. W is decoded from the wait code in bits [21:18]: codes 0 to 9 give W equal to the code, and codes 10 to 15 give 11, 13, 15, 17, 21 and 25.
- R7: Before the address of an access appears, `mem_addr` stays 0 and chip select stays high for a gap whose length depends on the previous access:
  - none since reset: gap 0;
  - previous was a write: bits [25:23];
  - previous read, next write: bits [28:26] for the same area, [31:29] for a different area;
  - previous read, next read: bits [34:32] for the same area, [37:35] for a different area.
- R8: Two accesses are in the same area when their address bits from `AREA_LSB` upward are equal.
- R9: `mem_bs_n` is low only while chip select is low. It is low for the first 1 chip-select cycle when bit [22] is 0 and the first 2 when it is 1, cut short if chip select is low for fewer cycles.
- R10: The configuration word is sampled in the cycle the request is taken. Changing it afterwards does not alter that access.
- R11: On a read, `rsp_rdata` takes the value on `mem_dq_i` at the clock edge that ends the last strobe-low cycle. It keeps that value until the next read completes.
- R12: A zero field removes its phase entirely. The cycles from acceptance to `rsp_done` equal gap + address setup + strobe setup + (1 + W) + strobe hold + address hold, so an all-zero word gives one strobe cycle and `rsp_done` one cycle later.
- R13: `mem_rd_n` and `mem_we_n` are never low together. Neither is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 38 | Timing configuration word, sampled when a request is taken |
| req_valid | input | 1 | Host offers a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Block is idle and can take a request |
| rsp_done | output | 1 | One-cycle pulse at the end of an access |
| rsp_rdata | output | DATA_W | Word captured by the last read |
| mem_addr | output | ADDR_W | External address, 0 when parked |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_bs_n | output | 1 | Start strobe at the opening of chip select, active low |
| mem_dq_o | output | DATA_W | Write data toward the memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_i | input | DATA_W | Read data from the memory |

## Verification
The assertions assume that the host drops `req_valid` once the offer has been taken, and that `mem_dq_i` is only an input sampled at capture. They also assume the configuration word may change at any time, because only its sampled copy matters. The directed stimulus drives every request on the falling edge and holds it for exactly one rising edge. It changes the configuration word and the memory data only on falling edges, and during a strobe it varies the returned data cycle by cycle so that an early or late capture shows up as a wrong word.

// File: rtl/sram_cs_seq_pkg.sv
package sram_cs_seq_pkg;

    localparam int CFG_W  = 38;
    localparam int CNT_W  = 5;
    localparam int NUM_PH = 7;

    // Phase order is the cycle sequence; IDLE sits at index 0.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_GAP  = 3'd1,
        PH_ASU  = 3'd2,
        PH_CSS  = 3'd3,
        PH_STB  = 3'd4,
        PH_STH  = 3'd5,
        PH_AH   = 3'd6
    } phase_e;

    // Field layout, most significant first; addr_setup occupies bits [2:0].
    typedef struct packed {
        logic [2:0] gap_rr_diff;
        logic [2:0] gap_rr_same;
        logic [2:0] gap_rw_diff;
        logic [2:0] gap_rw_same;
        logic [2:0] gap_after_wr;
        logic       bs_long;
        logic [3:0] wait_code;
        logic [2:0] wr_hold;
        logic [2:0] wr_setup;
        logic [2:0] rd_hold;
        logic [2:0] rd_setup;
        logic [2:0] addr_hold;
        logic [2:0] addr_setup;
    } timing_cfg_t;

    // Nonlinear wait-code expansion.
    function automatic logic [CNT_W-1:0] wait_cycles(input logic [3:0] code);
        logic [CNT_W-1:0] w;
        if (code < 4'd10) begin
            w = {1'b0, code};
        end else begin
            case (code)
                4'd10:   w = 5'd11;
                4'd11:   w = 5'd13;
                4'd12:   w = 5'd15;
                4'd13:   w = 5'd17;
                4'd14:   w = 5'd21;
                default: w = 5'd25;
            endcase
        end
        return w;
    endfunction

    // Length in cycles of one phase; zero means the phase is skipped.
    function automatic logic [CNT_W-1:0] phase_len(input phase_e p,
                                                   input timing_cfg_t c,
                                                   input logic wr,
                                                   input logic [2:0] gap);
        logic [CNT_W-1:0] n;
        case (p)
            PH_GAP:  n = {2'b00, gap};
            PH_ASU:  n = {2'b00, c.addr_setup};
            PH_CSS:  n = {2'b00, (wr ? c.wr_setup : c.rd_setup)};
            PH_STB:  n = wait_cycles(c.wait_code) + 5'd1;
            PH_STH:  n = {2'b00, (wr ? c.wr_hold : c.rd_hold)};
            PH_AH:   n = {2'b00, c.addr_hold};
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sram_cs_seq_gap.sv
module sram_cs_seq_gap #(
    parameter int AREA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              nxt_write,
    input  logic [AREA_W-1:0] nxt_area,
    input  logic [2:0]        gap_after_wr,
    input  logic [2:0]        gap_rw_same,
    input  logic [2:0]        gap_rw_diff,
    input  logic [2:0]        gap_rr_same,
    input  logic [2:0]        gap_rr_diff,
    output logic [2:0]        gap_o
);
    logic              have_prev_q;
    logic              prev_wr_q;
    logic [AREA_W-1:0] prev_area_q;
    logic              same_area;

    assign same_area = (prev_area_q == nxt_area);

    always_comb begin
        if (!have_prev_q) begin
            gap_o = 3'd0;
        end else if (prev_wr_q) begin
            gap_o = gap_after_wr;
        end else if (nxt_write) begin
            gap_o = same_area ? gap_rw_same : gap_rw_diff;
        end else begin
            gap_o = same_area ? gap_rr_same : gap_rr_diff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev_q <= 1'b0;
            prev_wr_q   <= 1'b0;
            prev_area_q <= '0;
        end else if (start) begin
            have_prev_q <= 1'b1;
            prev_wr_q   <= nxt_write;
            prev_area_q <= nxt_area;
        end
    end
endmodule

// File: rtl/sram_cs_seq_phase.sv
module sram_cs_seq_phase
    import sram_cs_seq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [NUM_PH-1:0][CNT_W-1:0] lens,
    output phase_e                       ph_o,
    output logic                         cap_o,
    output logic                         done_o
);
    phase_e           ph_q;
    phase_e           nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    int               seek_from;

    // First phase at or after 'from' whose length is nonzero.
    function automatic phase_e first_live(input int from,
                                          input logic [NUM_PH-1:0][CNT_W-1:0] l);
        phase_e r;
        logic   hit;
        r   = PH_IDLE;
        hit = 1'b0;
        for (int i = 0; i < NUM_PH; i++) begin
            if (!hit && i >= from && l[i] != '0) begin
                r   = phase_e'(3'(i));
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    always_comb begin
        seek_from = (ph_q == PH_IDLE) ? int'(PH_GAP) : int'(ph_q) + 1;
        nxt       = first_live(seek_from, lens);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ph_q == PH_IDLE) begin
                if (start) begin
                    ph_q  <= nxt;
                    cnt_q <= lens[nxt] - 1'b1;
                end
            end else if (cnt_q == '0) begin
                ph_q <= nxt;
                if (nxt == PH_IDLE) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= lens[nxt] - 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign ph_o   = ph_q;
    assign cap_o  = (ph_q == PH_STB) && (cnt_q == '0);
    assign done_o = done_q;
endmodule

// File: rtl/sram_cs_seq_pins.sv
module sram_cs_seq_pins
    import sram_cs_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            ph,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bs_long,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_we_n,
    output logic              mem_bs_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] rdata
);
    logic             addr_on;
    logic             cs_on;
    logic             stb_on;
    logic [1:0]       age_q;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        addr_on = (ph == PH_ASU) || (ph == PH_CSS) || (ph == PH_STB) ||
                  (ph == PH_STH) || (ph == PH_AH);
        cs_on   = (ph == PH_CSS) || (ph == PH_STB) || (ph == PH_STH);
        stb_on  = (ph == PH_STB);
    end

    assign mem_addr  = addr_on ? addr : '0;
    assign mem_cs_n  = !cs_on;
    assign mem_rd_n  = !(stb_on && !wr);
    assign mem_we_n  = !(stb_on && wr);
    assign mem_dq_oe = cs_on && wr;
    assign mem_dq_o  = mem_dq_oe ? wdata : '0;
    assign mem_bs_n  = !(cs_on && ((age_q == 2'd0) || (age_q == 2'd1 && bs_long)));
    assign rdata     = rdata_q;

    // Counts chip-select-low cycles, saturating.
    always_ff @(posedge clk) begin
        if (rst || !cs_on) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (cap && !wr) begin
            rdata_q <= dq_i;
        end
    end
endmodule

// File: rtl/sram_cs_seq.sv
module sram_cs_seq
    import sram_cs_seq_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int AREA_LSB = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_we_n,
    output logic              mem_bs_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int AREA_W = ADDR_W - AREA_LSB;

    phase_e                       ph;
    logic                         start;
    logic                         cap;
    timing_cfg_t                  cfg_q;
    timing_cfg_t                  cfg_eff;
    logic                         wr_q;
    logic                         wr_eff;
    logic [ADDR_W-1:0]            addr_q;
    logic [DATA_W-1:0]            wdata_q;
    logic [2:0]                   gap_cnt;
    logic [NUM_PH-1:0][CNT_W-1:0] lens;

    assign req_ready = (ph == PH_IDLE);
    assign start     = req_valid && req_ready;
    assign cfg_eff   = start ? timing_cfg_t'(cfg_word) : cfg_q;
    assign wr_eff    = start ? req_write : wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            cfg_q   <= timing_cfg_t'(cfg_word);
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    generate
        for (genvar g = 0; g < NUM_PH; g++) begin : g_len
            assign lens[g] = phase_len(phase_e'(3'(g)), cfg_eff, wr_eff, gap_cnt);
        end
    endgenerate

    sram_cs_seq_gap #(
        .AREA_W(AREA_W)
    ) u_gap (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .nxt_write    (req_write),
        .nxt_area     (req_addr[ADDR_W-1:AREA_LSB]),
        .gap_after_wr (cfg_eff.gap_after_wr),
        .gap_rw_same  (cfg_eff.gap_rw_same),
        .gap_rw_diff  (cfg_eff.gap_rw_diff),
        .gap_rr_same  (cfg_eff.gap_rr_same),
        .gap_rr_diff  (cfg_eff.gap_rr_diff),
        .gap_o        (gap_cnt)
    );

    sram_cs_seq_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .lens   (lens),
        .ph_o   (ph),
        .cap_o  (cap),
        .done_o (rsp_done)
    );

    sram_cs_seq_pins #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .wr        (wr_q),
        .addr      (addr_q),
        .wdata     (wdata_q),
        .bs_long   (cfg_q.bs_long),
        .cap       (cap),
        .dq_i      (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_rd_n  (mem_rd_n),
        .mem_we_n  (mem_we_n),
        .mem_bs_n  (mem_bs_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .rdata     (rsp_rdata)
    );
endmodule

// File: rtl/sram_cs_seq_chk.sv
module sram_cs_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_we_n,
    input logic              mem_bs_n,
    input logic              mem_dq_oe
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !rsp_done) |-> (mem_cs_n && mem_addr == '0 && !mem_dq_oe));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_done_with_ready_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> req_ready);

    assert_addr_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    assert_wdata_driven_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);

    assert_oe_in_cs_R5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_cs_n);

    assert_bs_in_cs_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_bs_n |-> !mem_cs_n);

    assert_rd_in_cs_R13: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> !mem_cs_n);

    assert_we_in_cs_R13: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> mem_we_n);
endmodule

bind sram_cs_seq sram_cs_seq_chk #(
    .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_we_n  (mem_we_n),
    .mem_bs_n  (mem_bs_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_cs_seq_tb.sv
module sram_cs_seq_tb;
    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [37:0]   cfg_word = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_rd_n, mem_we_n, mem_bs_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = 16'hDEAD;

    int checks = 0;
    int errors = 0;

    // bench history model for gap selection
    bit            have_prev = 0;
    bit            prev_wr = 0;
    logic [3:0]    prev_area = '0;
    logic [DW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    sram_cs_seq u_dut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [37:0] mk(input int as, input int ah, input int rs,
                                       input int rh, input int ws, input int wh,
                                       input int wc, input int bl, input int gw,
                                       input int grws, input int grwd,
                                       input int grrs, input int grrd);
        return {3'(grrd), 3'(grrs), 3'(grwd), 3'(grws), 3'(gw), 1'(bl), 4'(wc),
                3'(wh), 3'(ws), 3'(rh), 3'(rs), 3'(ah), 3'(as)};
    endfunction

    function automatic int wait_of(input int c);
        case (c)
            10: return 11;
            11: return 13;
            12: return 15;
            13: return 17;
            14: return 21;
            15: return 25;
            default: return c;
        endcase
    endfunction

    // Runs one access, measures every phase at the pins and checks it.
    task automatic do_access(input bit wr, input logic [AW-1:0] a,
                             input logic [DW-1:0] wd, input logic [37:0] c,
                             input logic [37:0] c_late, input string tag);
        int gap = 0, asu = 0, css = 0, stb = 0, sth = 0, ah = 0, bsn = 0, n = 0;
        int e_gap, e_css, e_stb, e_sth, e_bs, lcs;
        bit seen_cs = 0, seen_stb = 0, pat_ok = 1, wd_ok = 1, busy_ok = 1;
        logic [3:0] area;
        area = a[23:20];
        // expected gap (R7, R8)
        if (!have_prev) e_gap = 0;
        else if (prev_wr) e_gap = int'(c[25:23]);
        else if (wr) e_gap = (prev_area == area) ? int'(c[28:26]) : int'(c[31:29]);
        else e_gap = (prev_area == area) ? int'(c[34:32]) : int'(c[37:35]);
        e_css = wr ? int'(c[14:12]) : int'(c[8:6]);
        e_sth = wr ? int'(c[17:15]) : int'(c[11:9]);
        e_stb = 1 + wait_of(int'(c[21:18]));
        lcs   = e_css + e_stb + e_sth;
        e_bs  = (c[22] ? 2 : 1);
        if (e_bs > lcs) e_bs = lcs;

        @(negedge clk);
        chk({tag, " R2 ready before request"}, int'(req_ready), 1);
        cfg_word = c; req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_word  = c_late;
        while (!rsp_done && n < 200) begin
            if (req_ready) busy_ok = 0;
            if (!mem_cs_n) begin
                seen_cs = 1;
                if (mem_addr != a) pat_ok = 0;
                if (!mem_bs_n) bsn++;
                if (wr && (!mem_dq_oe || mem_dq_o != wd)) wd_ok = 0;
                if (!wr && mem_dq_oe) wd_ok = 0;
                if (!mem_rd_n || !mem_we_n) begin
                    if (!mem_rd_n && !mem_we_n) pat_ok = 0;
                    if (wr ? !mem_rd_n : !mem_we_n) pat_ok = 0;
                    if (seen_stb && (sth != 0)) pat_ok = 0;
                    mem_dq_i = wd + DW'(stb);
                    stb++;
                    seen_stb = 1;
                end else begin
                    mem_dq_i = 16'hDEAD;
                    if (seen_stb) sth++; else css++;
                end
            end else begin
                mem_dq_i = 16'hDEAD;
                if (!mem_rd_n || !mem_we_n || !mem_bs_n || mem_dq_oe) pat_ok = 0;
                if (mem_addr == '0) begin
                    if (seen_cs || asu != 0) pat_ok = 0;
                    gap++;
                end else if (mem_addr == a) begin
                    if (seen_cs) ah++; else asu++;
                end else begin
                    pat_ok = 0;
                end
            end
            n++;
            @(negedge clk);
        end
        chk({tag, " R2 done reached"}, int'(rsp_done), 1);
        chk({tag, " R2 ready low while busy"}, int'(busy_ok), 1);
        chk({tag, " R2 ready with done"}, int'(req_ready), 1);
        chk({tag, " R7 idle gap"}, gap, e_gap);
        chk({tag, " R3 address setup"}, asu, int'(c[2:0]));
        chk({tag, " R3 address hold"}, ah, int'(c[5:3]));
        chk({tag, wr ? " R5 strobe setup" : " R4 strobe setup"}, css, e_css);
        chk({tag, " R6 strobe width"}, stb, e_stb);
        chk({tag, wr ? " R5 strobe hold" : " R4 strobe hold"}, sth, e_sth);
        chk({tag, " R9 start strobe"}, bsn, e_bs);
        chk({tag, " R12 total cycles"}, n, e_gap + int'(c[2:0]) + lcs + int'(c[5:3]));
        chk({tag, " R13 pin pattern"}, int'(pat_ok), 1);
        chk({tag, " R5 data drive"}, int'(wd_ok), 1);
        if (!wr) begin
            last_rd = wd + DW'(e_stb - 1);
            chk({tag, " R11 read capture"}, int'(rsp_rdata), int'(last_rd));
        end else begin
            chk({tag, " R11 rdata held"}, int'(rsp_rdata), int'(last_rd));
        end
        @(negedge clk);
        chk({tag, " R2 done one cycle"}, int'(rsp_done), 0);
        have_prev = 1; prev_wr = wr; prev_area = area;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", int'(req_ready), 1);
        chk("R1 strobes idle", int'({mem_cs_n, mem_rd_n, mem_we_n, mem_bs_n}), 15);
        chk("R1 addr parked", int'(mem_addr), 0);
        chk("R1 no drive", int'(mem_dq_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done low", int'(rsp_done), 0);
        chk("R1 ready after reset", int'(req_ready), 1);
        have_prev = 0;
        last_rd = '0;
    endtask

    task automatic t_basic();
        logic [37:0] c1, c2;
        c1 = mk(2, 1, 1, 2, 2, 1, 3, 0, 5, 1, 2, 3, 4);
        c2 = mk(1, 3, 3, 1, 2, 1, 0, 1, 5, 1, 2, 3, 4);
        do_access(0, 24'h100010, 16'h1200, c1, c1, "basic-read");
        do_access(1, 24'h100020, 16'hA55A, c2, c2, "basic-write");
    endtask

    task automatic t_wait_codes();
        logic [37:0] c;
        int codes[4] = '{9, 10, 13, 15};
        foreach (codes[k]) begin
            c = mk(1, 1, 1, 1, 1, 1, codes[k], 0, 0, 0, 0, 0, 0);
            do_access(0, 24'h300040, 16'h0100 * DW'(k + 1), c, c, "R6-wait");
        end
    endtask

    task automatic t_gaps();
        logic [37:0] c;
        c = mk(1, 0, 0, 0, 0, 0, 0, 0, 5, 1, 2, 3, 4);
        do_access(0, 24'h200004, 16'h2000, c, c, "R7-first");
        do_access(0, 24'h2F0008, 16'h2100, c, c, "R8-read-same");
        do_access(0, 24'h500008, 16'h2200, c, c, "R8-read-diff");
        do_access(1, 24'h5000F0, 16'h3333, c, c, "R8-rw-same");
        do_access(0, 24'h600000, 16'h2300, c, c, "R7-after-write");
        do_access(1, 24'h700000, 16'h4444, c, c, "R8-rw-diff");
    endtask

    task automatic t_zero();
        logic [37:0] z, zb;
        z  = '0;
        zb = mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        do_access(0, 24'h800001, 16'h5000, z, z, "R12-zero-read");
        do_access(1, 24'h800002, 16'h5151, zb, zb, "R12-zero-write-bs");
    endtask

    task automatic t_cfg_change();
        logic [37:0] c_old, c_new;
        c_old = mk(3, 2, 2, 1, 1, 2, 4, 1, 1, 1, 1, 2, 1);
        c_new = mk(7, 7, 7, 7, 7, 7, 15, 0, 7, 7, 7, 7, 7);
        do_access(0, 24'h900100, 16'h6000, c_old, c_new, "R10-read");
        do_access(1, 24'h900200, 16'h6A6A, c_old, c_new, "R10-write");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_wait_codes();
        t_gaps();
        t_zero();
        t_cfg_change();
        t_reset();
        do_access(0, 24'hA00000, 16'h7000, mk(0, 0, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0),
                  '0, "R1-first-after-reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule